// File: doc/BRIEF.md
# Oversampled Serial Receiver with Stop-Bit Check

This block receives asynchronous serial frames for a small controller-style serial port. A 16x oversampling tick from an external baud generator paces it. Each frame has one low start bit, then the data least significant bit first, then a stop bit. One format carries eight data bits. Two further formats carry a ninth data bit ahead of the stop bit. Every bit value is the 2-of-3 majority of three samples taken around the middle of the bit. A start bit that does not hold low through the middle of its bit is treated as noise and dropped.

Software reaches the block through an 8-bit control/status register. Its most significant bit has two meanings, selected by a separate enable input. With the enable at 0 that bit is the upper mode-select bit. With the enable at 1 it is a sticky stop-bit error flag. The enable also moves the point in the frame where the receive-complete flag rises: at the end of the last data bit when the check is off, and at the stop-bit sample when it is on.

Top module: `uart_fe_rx`

## Requirements
- R1: The mode field is control bits {7,6}, with bit 7 read as the mode bit only while `fe_en` is 0. Mode 01 receives 8 data bits. Modes 10 and 11 receive 9 data bits. Mode 00 accepts no frame. Data bits arrive LSB first after one start bit, and the low eight appear on `rx_byte`.
- R2: The stop-error flag is set only when `fe_en` is 1 and the stop bit samples as 0. With `fe_en` at 0 it is never set by a frame.
- R3: Control bit 2 holds the ninth data bit in modes 10 and 11. In mode 01 it holds the sampled stop bit.
- R4: Once set, the stop-error flag stays set through later frames with a good stop bit. Only a write of 0 to bit 7 while `fe_en` is 1, or a reset, clears it.
- R5: While `fe_en` is 1, reads and writes of control bit 7 reach the stop-error flag. While `fe_en` is 0, they reach the upper mode bit. The bit not selected keeps its value.
- R6: Control bit 0, receive complete, rises at the end of the last data bit when `fe_en` is 0, and at the stop-bit sample when `fe_en` is 1.
- R7: A falling edge on the line starts a frame only if the majority of samples 7, 8 and 9 of that bit is low. Otherwise the receiver returns to idle, and flags and data stay unchanged.
- R8: Reset clears the whole control register and `rx_byte`. A software write of 0 to bit 0 clears receive complete.
- R9: While receive enable, control bit 4, is 0, no frame is started, and `rx_byte` and the flags are unchanged.
- R10: `rx_byte` changes only in the cycle in which receive complete is set. The bits of the control register not named in R1 to R9 (5, 3 and 1) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| fe_en | input | 1 | Enables the stop-bit check and selects the meaning of bit 7 |
| ctl_rdata | output | 8 | Control register read value |
| rx_byte | output | 8 | Last received data byte |

## Verification
The bench sends frames in all three formats, with mixed data patterns and both stop-bit values, under each setting of the enable. This separates the data path and the ninth-bit/stop-bit capture from the error path. Sequences of a bad stop followed by good stops, with and without an explicit clear, show the flag is sticky. Writing bit 7 with the enable at each level shows the two underlying bits are independent. The flag is sampled in the gap between the last data bit and the stop sample to tell the two completion points apart. A short low pulse, a frame sent with receive enable off, and a frame sent in mode 00 each show that nothing is accepted.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC  = 2'b00,
    MODE_8BIT  = 2'b01,
    MODE_9BITA = 2'b10,
    MODE_9BITB = 2'b11
  } rx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam int CTL_W   = 8;
  localparam int B_MSEL  = 7;
  localparam int B_MLO   = 6;
  localparam int B_REN   = 4;
  localparam int B_RB8   = 2;
  localparam int B_RI    = 0;
  localparam int DATA_MAX = 9;
endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = din;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_fe_vote.sv
module uart_fe_vote #(
  parameter int OSR = 16,
  parameter int CW  = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          rxd_s,
  output logic          vote_now,
  output logic          bit_val
);
  localparam int MID = OSR / 2;

  logic s_a_q, s_a_d;
  logic s_b_q, s_b_d;

  always_comb begin
    s_a_d = s_a_q;
    s_b_d = s_b_q;
    if (tick && cnt == CW'(MID - 1)) s_a_d = rxd_s;
    if (tick && cnt == CW'(MID))     s_b_d = rxd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else begin
      s_a_q <= s_a_d;
      s_b_q <= s_b_d;
    end
  end

  assign vote_now = tick && (cnt == CW'(MID + 1));
  assign bit_val  = (s_a_q & s_b_q) | (s_a_q & rxd_s) | (s_b_q & rxd_s);
endmodule

// File: rtl/uart_fe_frame.sv
module uart_fe_frame
  import uart_fe_pkg::*;
#(
  parameter int OSR = 16,
  parameter int CW  = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          ren,
  input  logic          rx_on,
  input  logic          nine_sel,
  input  logic          vote_now,
  input  logic          bit_val,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          data_done,
  output logic          stop_done,
  output logic          stop_val,
  output logic [7:0]    byte_out,
  output logic          ninth_out,
  output logic          frame_nine
);
  localparam int BW = $clog2(DATA_MAX + 1);

  rx_state_e            st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bidx_q, bidx_d;
  logic [DATA_MAX-1:0]  sh_q, sh_d;
  logic                 prev_q, prev_d;
  logic                 nine_q, nine_d;
  logic                 bit_end;
  logic [BW-1:0]        last_idx;

  assign bit_end  = tick && (cnt_q == CW'(OSR - 1));
  assign last_idx = nine_q ? BW'(DATA_MAX - 1) : BW'(DATA_MAX - 2);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    bidx_d    = bidx_q;
    sh_d      = sh_q;
    prev_d    = prev_q;
    nine_d    = nine_q;
    data_done = 1'b0;
    stop_done = 1'b0;
    if (tick) prev_d = rxd_s;
    if (st_q == ST_IDLE) begin
      if (tick && prev_q && !rxd_s && ren && rx_on) begin
        st_d   = ST_START;
        cnt_d  = '0;
        nine_d = nine_sel;
      end
    end else if (tick) begin
      cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    end
    case (st_q)
      ST_START: begin
        if (vote_now && bit_val) begin
          st_d = ST_IDLE;
        end else if (bit_end) begin
          st_d   = ST_DATA;
          bidx_d = '0;
        end
      end
      ST_DATA: begin
        if (vote_now) sh_d = {bit_val, sh_q[DATA_MAX-1:1]};
        if (bit_end) begin
          if (bidx_q == last_idx) begin
            data_done = 1'b1;
            st_d      = ST_STOP;
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (vote_now) begin
          stop_done = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      nine_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      prev_q <= prev_d;
      nine_q <= nine_d;
    end
  end

  assign cnt        = cnt_q;
  assign busy       = (st_q != ST_IDLE);
  assign stop_val   = bit_val;
  assign frame_nine = nine_q;
  assign byte_out   = nine_q ? sh_q[7:0] : sh_q[8:1];
  assign ninth_out  = sh_q[8];
endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             fe_en,
  input  logic             data_done,
  input  logic             stop_done,
  input  logic             stop_val,
  input  logic [7:0]       byte_in,
  input  logic             ninth_in,
  input  logic             frame_nine,
  output logic [CTL_W-1:0] rdata,
  output logic [7:0]       rx_byte,
  output rx_mode_e         mode,
  output logic             ren,
  output logic             fe_flag,
  output logic             ri_flag
);
  logic       sm0_q, sm0_d;
  logic       sm1_q, sm1_d;
  logic       ren_q, ren_d;
  logic       rb8_q, rb8_d;
  logic       ri_q, ri_d;
  logic       fe_q, fe_d;
  logic [7:0] byte_q, byte_d;
  logic       ri_set;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[5], wdata[3], wdata[1]};
  assign ri_set       = fe_en ? stop_done : data_done;

  always_comb begin
    sm0_d  = sm0_q;
    sm1_d  = sm1_q;
    ren_d  = ren_q;
    rb8_d  = rb8_q;
    ri_d   = ri_q;
    fe_d   = fe_q;
    byte_d = byte_q;
    if (wr) begin
      if (fe_en) fe_d  = wdata[B_MSEL];
      else       sm0_d = wdata[B_MSEL];
      sm1_d = wdata[B_MLO];
      ren_d = wdata[B_REN];
      rb8_d = wdata[B_RB8];
      ri_d  = wdata[B_RI];
    end
    if (ri_set) begin
      ri_d   = 1'b1;
      byte_d = byte_in;
      if (frame_nine) rb8_d = ninth_in;
    end
    if (stop_done && !frame_nine) rb8_d = stop_val;
    if (stop_done && fe_en && !stop_val) fe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm0_q  <= 1'b0;
      sm1_q  <= 1'b0;
      ren_q  <= 1'b0;
      rb8_q  <= 1'b0;
      ri_q   <= 1'b0;
      fe_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      sm0_q  <= sm0_d;
      sm1_q  <= sm1_d;
      ren_q  <= ren_d;
      rb8_q  <= rb8_d;
      ri_q   <= ri_d;
      fe_q   <= fe_d;
      byte_q <= byte_d;
    end
  end

  assign rdata   = {(fe_en ? fe_q : sm0_q), sm1_q, 1'b0, ren_q, 1'b0, rb8_q, 1'b0, ri_q};
  assign rx_byte = byte_q;
  assign mode    = rx_mode_e'({sm0_q, sm1_q});
  assign ren     = ren_q;
  assign fe_flag = fe_q;
  assign ri_flag = ri_q;
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       fe_en,
  output logic [7:0] ctl_rdata,
  output logic [7:0] rx_byte
);
  localparam int CW = $clog2(OSR);

  logic          rxd_s;
  logic [CW-1:0] cnt;
  logic          vote_now, bit_val;
  logic          data_done, stop_done, stop_val;
  logic [7:0]    byte_w;
  logic          ninth_w, frame_nine;
  rx_mode_e      mode;
  logic          rx_ren, rx_busy, fe_flag, ri_flag;
  logic          rx_on, nine_sel;

  assign rx_on    = (mode != MODE_SYNC);
  assign nine_sel = (mode == MODE_9BITA) || (mode == MODE_9BITB);

  uart_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  uart_fe_vote #(.OSR(OSR), .CW(CW)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cnt(cnt), .rxd_s(rxd_s),
    .vote_now(vote_now), .bit_val(bit_val)
  );

  uart_fe_frame #(.OSR(OSR), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_s(rxd_s), .ren(rx_ren),
    .rx_on(rx_on), .nine_sel(nine_sel), .vote_now(vote_now), .bit_val(bit_val),
    .cnt(cnt), .busy(rx_busy), .data_done(data_done), .stop_done(stop_done),
    .stop_val(stop_val), .byte_out(byte_w), .ninth_out(ninth_w),
    .frame_nine(frame_nine)
  );

  uart_fe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .fe_en(fe_en),
    .data_done(data_done), .stop_done(stop_done), .stop_val(stop_val),
    .byte_in(byte_w), .ninth_in(ninth_w), .frame_nine(frame_nine),
    .rdata(ctl_rdata), .rx_byte(rx_byte), .mode(mode), .ren(rx_ren),
    .fe_flag(fe_flag), .ri_flag(ri_flag)
  );
endmodule

// File: rtl/uart_fe_rx_chk.sv
module uart_fe_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       fe_en,
  input logic       fe_flag,
  input logic       ri_flag,
  input logic       rx_busy,
  input logic       rx_ren,
  input logic [7:0] rx_byte
);
  assert_fe_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_flag) |-> $past(ctl_wr && fe_en && !ctl_wdata[7]));

  assert_fe_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_flag) |-> $past(fe_en));

  assert_ri_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri_flag) |-> $past(ctl_wr && !ctl_wdata[0]));

  assert_start_needs_ren_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(rx_ren));

  assert_byte_with_ri_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> ri_flag);
endmodule

bind uart_fe_rx uart_fe_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .fe_en(fe_en), .fe_flag(fe_flag), .ri_flag(ri_flag), .rx_busy(rx_busy),
  .rx_ren(rx_ren), .rx_byte(rx_byte)
);

// File: tb/tb_uart_fe_rx.sv
module tb_uart_fe_rx;
  localparam int CLK_P   = 10;
  localparam int BIT_CLK = 32;
  localparam int NVEC    = 8;

  // {mode[1:0], fe_en, clear_fe, data[8:0], stop, exp_byte[7:0], exp_rb8, exp_fe}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 1'b1, 9'h0A5, 1'b1, 8'hA5, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b1, 9'h03C, 1'b0, 8'h3C, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b0, 9'h00F, 1'b1, 8'h0F, 1'b1, 1'b1},
    {2'b10, 1'b1, 1'b1, 9'h181, 1'b1, 8'h81, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b0, 9'h07E, 1'b0, 8'h7E, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b0, 9'h100, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b0, 9'h0FF, 1'b1, 8'hFF, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b1, 9'h055, 1'b1, 8'h55, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       fe_en = 1'b0;
  logic [7:0] ctl_rdata;
  logic [7:0] rx_byte;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  uart_fe_rx dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .fe_en(fe_en),
    .ctl_rdata(ctl_rdata), .rx_byte(rx_byte)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrctl(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic nine, input logic stopb);
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold(d[i], BIT_CLK);
    if (nine) hold(d[8], BIT_CLK);
    hold(stopb, BIT_CLK);
    hold(1'b1, 2 * BIT_CLK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    logic [8:0] d;
    logic [7:0] prev_byte;
    repeat (5) @(negedge clk);
    chk("R8 reset ctl", ctl_rdata, 8'h00);
    chk("R8 reset byte", rx_byte, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: formats, data patterns, stop values, enable, sticky flag
    for (int v = 0; v < NVEC; v++) begin
      m = VEC[v][23:22];
      d = VEC[v][19:11];
      fe_en = 1'b0;
      wrctl({m[1], m[0], 1'b0, 1'b1, 4'b0000});
      fe_en = 1'b1;
      if (VEC[v][20]) wrctl({1'b0, m[0], 1'b0, 1'b1, 4'b0000});
      fe_en = VEC[v][21];
      send_frame(d, m[1], VEC[v][10]);
      chk($sformatf("R1 byte vec%0d", v), rx_byte, VEC[v][9:2]);
      chk($sformatf("R3 rb8 vec%0d", v), ctl_rdata[2], VEC[v][1]);
      chk($sformatf("R6 ri vec%0d", v), ctl_rdata[0], 1);
      fe_en = 1'b1;
      @(negedge clk);
      chk($sformatf("R2 R4 fe vec%0d", v), ctl_rdata[7], VEC[v][0]);
      fe_en = 1'b0;
      @(negedge clk);
      chk($sformatf("R5 mode bit vec%0d", v), ctl_rdata[7], m[1]);
    end

    // R8: software clear of receive complete; R10 unused bits read 0
    fe_en = 1'b0;
    wrctl(8'b0101_0000);
    chk("R8 ri cleared", ctl_rdata[0], 0);
    chk("R10 spare bits", ctl_rdata & 8'h2A, 0);

    // R6: completion point with check off vs on (mode 01)
    for (int e = 0; e < 2; e++) begin
      fe_en = 1'b0;
      wrctl(8'b0101_0000);
      fe_en = e[0];
      fork
        send_frame(9'h0C3, 1'b0, 1'b1);
        begin
          repeat (300) @(negedge clk);
          chk($sformatf("R6 ri mid-stop fe_en=%0d", e), ctl_rdata[0], (e == 0) ? 1 : 0);
        end
      join
      chk($sformatf("R6 ri after frame fe_en=%0d", e), ctl_rdata[0], 1);
      chk($sformatf("R1 byte C3 fe_en=%0d", e), rx_byte, 8'hC3);
    end

    // R7: short low pulse is rejected
    fe_en = 1'b0;
    wrctl(8'b0101_0000);
    prev_byte = rx_byte;
    hold(1'b0, 4);
    hold(1'b1, 3 * BIT_CLK);
    chk("R7 glitch no ri", ctl_rdata[0], 0);
    chk("R7 glitch byte kept", rx_byte, prev_byte);
    send_frame(9'h096, 1'b0, 1'b1);
    chk("R7 frame after glitch", rx_byte, 8'h96);

    // R9: receive enable off
    wrctl(8'b0100_0000);
    send_frame(9'h011, 1'b0, 1'b1);
    chk("R9 ren off no ri", ctl_rdata[0], 0);
    chk("R9 ren off byte kept", rx_byte, 8'h96);

    // R1: mode 00 accepts nothing
    wrctl(8'b0001_0000);
    send_frame(9'h022, 1'b0, 1'b1);
    chk("R1 mode00 no ri", ctl_rdata[0], 0);
    chk("R1 mode00 byte kept", rx_byte, 8'h96);

    // R5/R4: independent underlying bits of bit 7
    wrctl(8'b0101_0000);
    fe_en = 1'b1;
    send_frame(9'h0AA, 1'b0, 1'b0);
    chk("R2 fe set on bad stop", ctl_rdata[7], 1);
    fe_en = 1'b0;
    wrctl(8'b1101_0000);
    chk("R5 mode bit written", ctl_rdata[7], 1);
    fe_en = 1'b1;
    @(negedge clk);
    chk("R4 R5 fe kept across mode write", ctl_rdata[7], 1);
    wrctl(8'b0101_0000);
    chk("R4 fe cleared by write", ctl_rdata[7], 0);
    fe_en = 1'b0;
    @(negedge clk);
    chk("R5 mode bit kept across fe write", ctl_rdata[7], 1);

    // R8: reset mid-state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 reset again ctl", ctl_rdata, 8'h00);
    chk("R8 reset again byte", rx_byte, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule